// File: doc/BRIEF.md
# Table Pointer and Data Latch Unit

This block moves single bytes between a program memory and an 8-bit data latch, steered by a 22-bit byte pointer. A read command fetches the byte at the pointer into the latch. A write command deposits the latch value into one of eight byte-wide staging registers, chosen by the low three pointer bits. Two further commands drive the memory directly. One commits all eight staging bytes as one aligned 8-byte block. The other erases the aligned 64-byte block that holds the pointer.

Read and write commands carry a pointer-update mode: keep, post-increment, post-decrement or pre-increment. Updates wrap within the low 21 bits, so the top bit, which selects the separate identification and configuration space, only changes through a register write. Software-side logic reaches the three pointer bytes and the latch through a small register port. The memory side is a plain synchronous port with one cycle of read latency.

Top module: `tblptr_unit`

## Requirements
- R1: After reset the pointer and the latch are zero, all eight staging bytes are 8'hFF, and `busy`, `done`, `mem_rd`, `mem_blk_wr` and `mem_erase` are low.
- R2: `reg_sel` picks 0 = pointer bits 7:0, 1 = pointer bits 15:8, 2 = pointer bits 21:16, 3 = latch. `reg_rdata` shows the selected register combinationally. A write to select 2 takes only `reg_wdata[5:0]`, and reads of select 2 return zero in bits 7:6.
- R3: `cmd_mode` 0 keeps the pointer. 1 accesses at P and then sets P+1. 2 accesses at P and then sets P-1. 3 accesses at P+1 and leaves P+1. The pointer takes its new value in the cycle that `done` is high.
- R4: Pointer increments and decrements change bits 20:0 only, wrapping modulo 2^21. Bit 21 is never changed by them.
- R5: A read (`cmd_op` 0) raises `mem_rd` for one cycle, in the cycle after acceptance, with `mem_addr` equal to the full 22-bit access address. One cycle later the latch loads `mem_rdata`, and `done` is high in the cycle after that.
- R6: A write (`cmd_op` 1) copies the latch into staging byte number (access address bits 2:0). `done` is high in the cycle after acceptance.
- R7: A block write (`cmd_op` 2) raises `mem_blk_wr` for one cycle, in the cycle after acceptance. `mem_addr` is {pointer bits 21:3, 3'b000}, and `mem_wdata` bits 8i+7:8i carry staging byte i. The pointer does not change and `cmd_mode` is ignored.
- R8: After a block write, all eight staging bytes read 8'hFF.
- R9: An erase (`cmd_op` 3) raises `mem_erase` for one cycle, in the cycle after acceptance. `mem_addr` is {pointer bits 21:6, 6'b0}, so pointer bits 5:0 have no effect. The pointer does not change.
- R10: While `busy` is high, commands and register writes are ignored. A register write in the same cycle as an accepted command is also ignored.
- R11: At most one of `mem_rd`, `mem_blk_wr` and `mem_erase` is high in any cycle. Every accepted command gives exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when not busy |
| cmd_op | input | 2 | 0 read, 1 write, 2 block write, 3 erase |
| cmd_mode | input | 2 | Pointer mode for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register value |
| busy | output | 1 | Read in progress |
| done | output | 1 | Command completion pulse |
| mem_rd | output | 1 | Memory read request |
| mem_blk_wr | output | 1 | Memory 8-byte block write strobe |
| mem_erase | output | 1 | Memory 64-byte erase strobe |
| mem_addr | output | 22 | Memory address for the active strobe |
| mem_wdata | output | 64 | Eight staging bytes for a block write |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |

## Verification
Commands are accepted on edge E0. Write, block write and erase give their strobe, `done` and the new pointer in the cycle after E0. A read gives `mem_rd` in the cycle after E0, and the latch, the new pointer and `done` two cycles after that. The bench drives on falling edges and samples each result on the falling edge of exactly its cycle. It also confirms that the other strobes and `done` are low in the cycles between. Staging contents, which have no direct port, are checked through the `mem_wdata` of a later block write.

// File: rtl/tbl_pkg.sv
// Shared encodings for the table pointer unit.
// Assumes 2-bit command, mode and register-select fields at the top ports.
package tbl_pkg;
    typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_BLKWR = 2'd2, OP_ERASE = 2'd3} tbl_op_e;
    typedef enum logic [1:0] {MD_KEEP = 2'd0, MD_POSTINC = 2'd1, MD_POSTDEC = 2'd2, MD_PREINC = 2'd3} tbl_mode_e;
    typedef enum logic [1:0] {SEL_LOW = 2'd0, SEL_HIGH = 2'd1, SEL_UPPER = 2'd2, SEL_LATCH = 2'd3} tbl_sel_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_WAIT = 2'd2} tbl_state_e;
endpackage

// File: rtl/tbl_ptr_step.sv
// Pointer step logic: from the current pointer and an update mode, computes
// the address used for the access and the pointer value after the command.
// Assumes PTR_W > WRAP_W; bits above WRAP_W are carried through untouched.
module tbl_ptr_step #(
    parameter int PTR_W  = 22,
    parameter int WRAP_W = 21
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [1:0]       mode,
    output logic [PTR_W-1:0] acc_addr,
    output logic [PTR_W-1:0] next_ptr
);
    import tbl_pkg::*;

    logic [WRAP_W-1:0] low_inc;
    logic [WRAP_W-1:0] low_dec;
    logic [PTR_W-1:0]  ptr_inc;
    logic [PTR_W-1:0]  ptr_dec;

    // Wrapping increment and decrement of the low field only.
    always_comb begin
        low_inc = ptr[WRAP_W-1:0] + 1'b1;
        low_dec = ptr[WRAP_W-1:0] - 1'b1;
        ptr_inc = {ptr[PTR_W-1:WRAP_W], low_inc};
        ptr_dec = {ptr[PTR_W-1:WRAP_W], low_dec};
    end

    // Select access address and successor pointer by mode.
    always_comb begin
        acc_addr = ptr;
        next_ptr = ptr;
        case (tbl_mode_e'(mode))
            MD_POSTINC: next_ptr = ptr_inc;
            MD_POSTDEC: next_ptr = ptr_dec;
            MD_PREINC: begin
                acc_addr = ptr_inc;
                next_ptr = ptr_inc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tbl_hold_bank.sv
// Bank of byte-wide staging registers filled one at a time and cleared
// together to all ones. Assumes NHOLD is a power of two.
module tbl_hold_bank #(
    parameter int NHOLD = 8,
    parameter int DW    = 8,
    localparam int IDX_W = $clog2(NHOLD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DW-1:0]         wr_data,
    input  logic                  clr,
    output logic [NHOLD*DW-1:0]   hold_flat
);
    for (genvar g = 0; g < NHOLD; g++) begin : g_hold
        logic [DW-1:0] byte_q;

        // One staging byte: set to ones on reset or clear, load on match.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '1;
            else if (clr)
                byte_q <= '1;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                byte_q <= wr_data;
        end

        assign hold_flat[g*DW +: DW] = byte_q;
    end
endmodule

// File: rtl/tbl_ctrl.sv
// Command sequencer: holds the pointer and the latch, accepts commands when
// idle, runs the two-cycle memory read, and issues block-write and erase
// strobes. Assumes memory read data arrives one cycle after mem_rd.
module tbl_ctrl #(
    parameter int PTR_W     = 22,
    parameter int DW        = 8,
    parameter int NHOLD     = 8,
    parameter int BLK_LSB   = 3,
    parameter int ERASE_LSB = 6,
    localparam int IDX_W = $clog2(NHOLD),
    localparam int UP_W  = PTR_W - 2*DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [DW-1:0]        reg_wdata,
    input  logic [PTR_W-1:0]     acc_addr,
    input  logic [PTR_W-1:0]     next_ptr,
    input  logic [NHOLD*DW-1:0]  hold_flat,
    input  logic [DW-1:0]        mem_rdata,
    output logic [PTR_W-1:0]     ptr_q,
    output logic [DW-1:0]        latch_q,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_rd,
    output logic                 mem_blk_wr,
    output logic                 mem_erase,
    output logic [PTR_W-1:0]     mem_addr,
    output logic [NHOLD*DW-1:0]  mem_wdata,
    output logic                 hold_wr_en,
    output logic [IDX_W-1:0]     hold_wr_idx,
    output logic                 hold_clr
);
    import tbl_pkg::*;

    tbl_state_e        state_q;
    logic [PTR_W-1:0]  pend_ptr_q;
    logic              accept;
    logic              sw_wr;

    // Acceptance and software-write qualification.
    always_comb begin
        accept      = cmd_valid && (state_q == ST_IDLE);
        sw_wr       = reg_we && (state_q == ST_IDLE) && !cmd_valid;
        busy        = (state_q != ST_IDLE);
        mem_rd      = (state_q == ST_REQ);
        hold_wr_en  = accept && (tbl_op_e'(cmd_op) == OP_WRITE);
        hold_wr_idx = acc_addr[IDX_W-1:0];
        hold_clr    = accept && (tbl_op_e'(cmd_op) == OP_BLKWR);
    end

    // Main sequencer with pointer, latch and memory strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            latch_q    <= '0;
            pend_ptr_q <= '0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            done       <= 1'b0;
            mem_blk_wr <= 1'b0;
            mem_erase  <= 1'b0;
        end else begin
            done       <= 1'b0;
            mem_blk_wr <= 1'b0;
            mem_erase  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (tbl_op_e'(cmd_op))
                            OP_READ: begin
                                state_q    <= ST_REQ;
                                mem_addr   <= acc_addr;
                                pend_ptr_q <= next_ptr;
                            end
                            OP_WRITE: begin
                                ptr_q <= next_ptr;
                                done  <= 1'b1;
                            end
                            OP_BLKWR: begin
                                mem_addr   <= {ptr_q[PTR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};
                                mem_wdata  <= hold_flat;
                                mem_blk_wr <= 1'b1;
                                done       <= 1'b1;
                            end
                            default: begin
                                mem_addr  <= {ptr_q[PTR_W-1:ERASE_LSB], {ERASE_LSB{1'b0}}};
                                mem_erase <= 1'b1;
                                done      <= 1'b1;
                            end
                        endcase
                    end else if (sw_wr) begin
                        case (tbl_sel_e'(reg_sel))
                            SEL_LOW:   ptr_q[DW-1:0]          <= reg_wdata;
                            SEL_HIGH:  ptr_q[2*DW-1:DW]       <= reg_wdata;
                            SEL_UPPER: ptr_q[PTR_W-1:2*DW]    <= reg_wdata[UP_W-1:0];
                            default:   latch_q                <= reg_wdata;
                        endcase
                    end
                end
                ST_REQ: state_q <= ST_WAIT;
                default: begin
                    latch_q <= mem_rdata;
                    ptr_q   <= pend_ptr_q;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/tblptr_unit.sv
// Top of the table pointer and latch unit: ties the pointer step, the
// staging bank and the sequencer together and muxes the register read port.
// Assumes a synchronous memory with one-cycle read latency.
module tblptr_unit #(
    parameter int PTR_W     = 22,
    parameter int WRAP_W    = 21,
    parameter int DW        = 8,
    parameter int NHOLD     = 8,
    parameter int ERASE_LSB = 6,
    localparam int BLK_LSB = $clog2(NHOLD),
    localparam int IDX_W   = $clog2(NHOLD),
    localparam int UP_W    = PTR_W - 2*DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [1:0]           cmd_mode,
    input  logic                 reg_we,
    input  logic [1:0]           reg_sel,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_rd,
    output logic                 mem_blk_wr,
    output logic                 mem_erase,
    output logic [PTR_W-1:0]     mem_addr,
    output logic [NHOLD*DW-1:0]  mem_wdata,
    input  logic [DW-1:0]        mem_rdata
);
    import tbl_pkg::*;

    logic [PTR_W-1:0]     ptr_q;
    logic [DW-1:0]        latch_q;
    logic [PTR_W-1:0]     acc_addr;
    logic [PTR_W-1:0]     next_ptr;
    logic [NHOLD*DW-1:0]  hold_flat;
    logic                 hold_wr_en;
    logic [IDX_W-1:0]     hold_wr_idx;
    logic                 hold_clr;

    tbl_ptr_step #(.PTR_W(PTR_W), .WRAP_W(WRAP_W)) u_step (
        .ptr      (ptr_q),
        .mode     (cmd_mode),
        .acc_addr (acc_addr),
        .next_ptr (next_ptr)
    );

    tbl_hold_bank #(.NHOLD(NHOLD), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hold_wr_en),
        .wr_idx    (hold_wr_idx),
        .wr_data   (latch_q),
        .clr       (hold_clr),
        .hold_flat (hold_flat)
    );

    tbl_ctrl #(
        .PTR_W(PTR_W), .DW(DW), .NHOLD(NHOLD),
        .BLK_LSB(BLK_LSB), .ERASE_LSB(ERASE_LSB)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .acc_addr    (acc_addr),
        .next_ptr    (next_ptr),
        .hold_flat   (hold_flat),
        .mem_rdata   (mem_rdata),
        .ptr_q       (ptr_q),
        .latch_q     (latch_q),
        .busy        (busy),
        .done        (done),
        .mem_rd      (mem_rd),
        .mem_blk_wr  (mem_blk_wr),
        .mem_erase   (mem_erase),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .hold_wr_en  (hold_wr_en),
        .hold_wr_idx (hold_wr_idx),
        .hold_clr    (hold_clr)
    );

    // Register read mux; the upper byte is zero-extended.
    always_comb begin
        case (tbl_sel_e'(reg_sel))
            SEL_LOW:   reg_rdata = ptr_q[DW-1:0];
            SEL_HIGH:  reg_rdata = ptr_q[2*DW-1:DW];
            SEL_UPPER: reg_rdata = {{(DW-UP_W){1'b0}}, ptr_q[PTR_W-1:2*DW]};
            default:   reg_rdata = latch_q;
        endcase
    end
endmodule

// File: rtl/tbl_unit_chk.sv
// Protocol checker for tblptr_unit, attached by bind below.
module tbl_unit_chk #(
    parameter int PTR_W     = 22,
    parameter int HOLD_BITS = 64,
    parameter int BLK_LSB   = 3,
    parameter int ERASE_LSB = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  mem_rd,
    input logic                  mem_blk_wr,
    input logic                  mem_erase,
    input logic [PTR_W-1:0]      mem_addr,
    input logic [PTR_W-1:0]      ptr_q,
    input logic                  reg_we,
    input logic [1:0]            reg_sel,
    input logic [HOLD_BITS-1:0]  hold_flat
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_blk_wr, mem_erase}) <= 1); // R11
    AST_READ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ##2 done); // R5
    AST_READ_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (busy && !mem_rd)); // R10
    AST_BLK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_blk_wr |-> (mem_addr[BLK_LSB-1:0] == '0)); // R7
    AST_ERASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |-> (mem_addr[ERASE_LSB-1:0] == '0)); // R9
    AST_STAGING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_blk_wr |-> (&hold_flat)); // R8
    AST_TOP_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q[PTR_W-1] != $past(ptr_q[PTR_W-1])) |->
            $past(reg_we && (reg_sel == 2'd2) && !busy)); // R4
endmodule

bind tblptr_unit tbl_unit_chk #(
    .PTR_W(PTR_W), .HOLD_BITS(NHOLD*DW), .BLK_LSB(BLK_LSB), .ERASE_LSB(ERASE_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_rd     (mem_rd),
    .mem_blk_wr (mem_blk_wr),
    .mem_erase  (mem_erase),
    .mem_addr   (mem_addr),
    .ptr_q      (ptr_q),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .hold_flat  (hold_flat)
);

// File: tb/tb_tblptr_unit.sv
module tb_tblptr_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [1:0]  cmd_mode;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        busy, done, mem_rd, mem_blk_wr, mem_erase;
    logic [21:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [21:0] ptr_m;
    logic [7:0]  latch_m;
    logic [7:0]  hold_m [8];

    always #(CLK_P/2) clk = ~clk;

    tblptr_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mode(cmd_mode), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
        .mem_rd(mem_rd), .mem_blk_wr(mem_blk_wr), .mem_erase(mem_erase),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mem_fn(logic [21:0] a);
        return a[7:0] ^ {a[14:8], 1'b1} ^ {a[21:16], a[15], 1'b0};
    endfunction

    // Memory model: data one cycle after the request.
    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem_fn(mem_addr);

    function automatic logic [21:0] f_inc(logic [21:0] p);
        return {p[21], p[20:0] + 21'd1};
    endfunction
    function automatic logic [21:0] f_dec(logic [21:0] p);
        return {p[21], p[20:0] - 21'd1};
    endfunction
    function automatic logic [21:0] f_acc(logic [21:0] p, logic [1:0] m);
        return (m == 2'd3) ? f_inc(p) : p;
    endfunction
    function automatic logic [21:0] f_next(logic [21:0] p, logic [1:0] m);
        case (m)
            2'd1: return f_inc(p);
            2'd2: return f_dec(p);
            2'd3: return f_inc(p);
            default: return p;
        endcase
    endfunction
    function automatic logic [63:0] hold_vec();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = hold_m[i];
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic get_reg(logic [1:0] s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    // Compare pointer bytes and latch with the model (R2).
    task automatic chk_state(string req);
        logic [7:0] lo, hi, up, la;
        get_reg(2'd0, lo);
        get_reg(2'd1, hi);
        get_reg(2'd2, up);
        get_reg(2'd3, la);
        chk({up, hi, lo} == {2'b00, ptr_m}, req, "pointer", {up, hi, lo}, {2'b00, ptr_m});
        chk(la == latch_m, req, "latch", la, latch_m);
    endtask

    task automatic reg_write(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (s)
            2'd0: ptr_m[7:0]   = d;
            2'd1: ptr_m[15:8]  = d;
            2'd2: ptr_m[21:16] = d[5:0];
            default: latch_m   = d;
        endcase
    endtask

    task automatic set_ptr(logic [21:0] p);
        reg_write(2'd0, p[7:0]);
        reg_write(2'd1, p[15:8]);
        reg_write(2'd2, {2'b11, p[21:16]});
    endtask

    task automatic do_cmd(logic [1:0] op, logic [1:0] m);
        logic [21:0] acc, nxt;
        acc = f_acc(ptr_m, m);
        nxt = f_next(ptr_m, m);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_mode = m;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            2'd0: begin
                chk(mem_rd && busy && !done, "R5", "read request", {busy, mem_rd, done}, 3'b110);
                chk(mem_addr == acc, "R3", "read address", mem_addr, acc);
                @(negedge clk);
                chk(!done && !mem_rd && busy, "R5", "read wait", {busy, mem_rd, done}, 3'b100);
                @(negedge clk);
                chk(done && !busy, "R5", "read done", {busy, done}, 2'b01);
                latch_m = mem_fn(acc);
                ptr_m   = nxt;
                chk_state("R5");
            end
            2'd1: begin
                chk(done && !mem_rd && !mem_blk_wr && !mem_erase, "R6", "write done",
                    {done, mem_rd, mem_blk_wr, mem_erase}, 4'b1000);
                hold_m[acc[2:0]] = latch_m;
                ptr_m = nxt;
                chk_state("R6");
            end
            2'd2: begin
                chk(done && mem_blk_wr && !mem_erase && !mem_rd, "R7", "block strobe",
                    {done, mem_blk_wr, mem_erase, mem_rd}, 4'b1100);
                chk(mem_addr == {ptr_m[21:3], 3'b000}, "R7", "block address", mem_addr, {ptr_m[21:3], 3'b000});
                chk(mem_wdata == hold_vec(), "R7", "block data", mem_wdata, hold_vec());
                for (int i = 0; i < 8; i++) hold_m[i] = 8'hFF;
                chk_state("R7");
            end
            default: begin
                chk(done && mem_erase && !mem_blk_wr && !mem_rd, "R9", "erase strobe",
                    {done, mem_erase, mem_blk_wr, mem_rd}, 4'b1100);
                chk(mem_addr == {ptr_m[21:6], 6'b0}, "R9", "erase address", mem_addr, {ptr_m[21:6], 6'b0});
                chk_state("R9");
            end
        endcase
        @(negedge clk);
        chk(!done && !mem_blk_wr && !mem_erase && !mem_rd, "R11", "single pulse",
            {done, mem_blk_wr, mem_erase, mem_rd}, 4'b0000);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1234_5eed));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_mode = 2'd0;
        reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
        ptr_m = '0; latch_m = '0;
        for (int i = 0; i < 8; i++) hold_m[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk({busy, done, mem_rd, mem_blk_wr, mem_erase} == 5'b0, "R1", "outputs idle",
            {busy, done, mem_rd, mem_blk_wr, mem_erase}, 5'b0);
        chk_state("R1");
        do_cmd(2'd2, 2'd0); // R1: staging bytes are all ones after reset

        // R2: upper byte takes only 6 bits
        reg_write(2'd2, 8'hFF);
        get_reg(2'd2, d);
        chk(d == 8'h3F, "R2", "upper readback", d, 8'h3F);

        // R4: wrap at the 21-bit boundary, both directions, top bit kept
        set_ptr(22'h1FFFFF);
        do_cmd(2'd0, 2'd1);
        chk(ptr_m == 22'h000000, "R4", "model wrap up", ptr_m, 0);
        do_cmd(2'd0, 2'd2);
        set_ptr(22'h3FFFFF);
        do_cmd(2'd1, 2'd3);
        do_cmd(2'd1, 2'd2);
        set_ptr(22'h200000);
        do_cmd(2'd0, 2'd2);

        // R3: pre-increment accesses the new pointer
        set_ptr(22'h012347);
        reg_write(2'd3, 8'hA5);
        do_cmd(2'd1, 2'd3);
        do_cmd(2'd0, 2'd0);
        // R6 and R8: fill all eight bytes then commit twice
        set_ptr(22'h000100);
        for (int i = 0; i < 8; i++) begin
            reg_write(2'd3, 8'(8'h10 + i));
            do_cmd(2'd1, 2'd1);
        end
        do_cmd(2'd2, 2'd1);
        do_cmd(2'd2, 2'd0);

        // R9: low six bits have no effect on the erase address
        set_ptr(22'h2ABC7F);
        do_cmd(2'd3, 2'd1);

        // R10: command and register write during a read are ignored
        set_ptr(22'h000040);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_mode = 2'd1;
        @(negedge clk);
        cmd_op = 2'd2; reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h77;
        @(negedge clk);
        cmd_valid = 1'b0; reg_we = 1'b0;
        chk(!done && !mem_blk_wr, "R10", "no extra strobe", {done, mem_blk_wr}, 2'b00);
        @(negedge clk);
        chk(done && !mem_blk_wr, "R10", "read completes", {done, mem_blk_wr}, 2'b10);
        latch_m = mem_fn(22'h000040);
        ptr_m = 22'h000041;
        chk_state("R10");
        @(negedge clk);
        chk(!done, "R11", "one done", done, 0);

        // R10: register write beside an accepted command is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_mode = 2'd0;
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'hEE;
        @(negedge clk);
        cmd_valid = 1'b0; reg_we = 1'b0;
        chk(mem_erase, "R10", "erase taken", mem_erase, 1);
        chk_state("R10");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) begin
                case ($urandom % 4)
                    0: set_ptr(22'h1FFFFF);
                    1: set_ptr(22'h3FFFFF);
                    2: set_ptr(22'h200000);
                    default: set_ptr(22'($urandom));
                endcase
            end else if (r < 4) begin
                reg_write(2'd3, 8'($urandom));
            end else begin
                do_cmd(2'($urandom), 2'($urandom));
            end
        end
        do_cmd(2'd2, 2'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule